// File: doc/BRIEF.md
# Stream Packet Receiver with Register Read Port

This block accepts packets on a 32-bit valid/ready stream and holds them until software reads them through a small register port. Each packet ends on the word whose handshake carries the last flag. When that word is taken, the packet's word count goes into a separate length queue and a completion flag is raised. To read a packet, software first checks the occupancy register. It then reads the length register, which returns the byte count of the oldest finished packet and makes that packet the current one. Finally it reads the data register once per word.

The stream follows valid/ready rules. A word moves only in a cycle where both `s_valid` and `s_ready` are high. The sender must hold `s_data` and `s_last` steady while it waits. The block lowers `s_ready` when either the data store or the length queue is full, and also during a cycle that writes the reset key. Register reads return data in the same cycle, and their side effects take place at the clock edge that ends the access. Status bits are sticky. Software clears them by writing ones to them. The interrupt output is high while any status bit is set. A reset key written to one register flushes the receive path. The same key written to another register flushes the path and also clears all status.

Top module: `stream_pkt_rx`

## Requirements
- R1: `s_ready` is high exactly when the data store holds fewer than DEPTH words, the length queue holds fewer than LEN_DEPTH entries, and no reset key is being written in that cycle.
- R2: A handshake on a word with `s_last` set ends the packet and sets status bit 26 (packet done).
- R3: Reading offset 0x1C returns the number of stored words that belong to packets whose last word has arrived. Words of an unfinished packet are not counted.
- R4: Reading offset 0x24 returns four times the word count of the oldest finished packet and removes that entry from the queue. If no finished packet is queued, the read returns 0.
- R5: Reading offset 0x20 returns the words of the current packet in arrival order, one word per read.
- R6: Reading offset 0x20 while R3's count is zero returns 0 and sets status bit 29 (underrun).
- R7: Reading offset 0x20 when the current packet's words are all consumed, but other packets are stored, returns 0. It sets status bit 30 (over-read) and consumes no word.
- R8: Reading offset 0x24 while the current packet still has unread words sets status bit 31 (under-read).
- R9: Offset 0x00 reads the status word, and each bit written as one to it is cleared. A bit set by an event in the same cycle stays set. `irq` is high whenever any status bit is set.
- R10: Writing 0x000000A5 to offset 0x18 empties the data store and the length queue and sets status bit 23 (reset done). Any other value written there has no effect.
- R11: Writing 0x000000A5 to offset 0x28 empties the data store and the length queue and clears every status bit.
- R12: Status bit 20 is set when the stored word count rises to PFULL_THR or more. Status bit 19 is set when the count falls to PEMPTY_THR or less.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Stream word accepted when high together with s_valid |
| s_data | input | 32 | Stream data word |
| s_last | input | 1 | Marks the final word of a packet |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle of the read |
| irq | output | 1 | High while any status bit is set |

## Verification
The assertions take two things for granted about the inputs. First, a register read and a register write never happen in the same cycle. Second, no packet is longer than DEPTH words, because a longer packet could never complete and would hold the stream stalled. The stimulus issues one register access at a time through separate read and write tasks. Every packet it sends fits the store, including the single 16-word packet that fills it. The stream driver keeps its word and flag steady until it sees `s_ready`, so back-pressure never changes the data that is accepted.

// File: rtl/stream_pkt_rx_pkg.sv
package stream_pkt_rx_pkg;
  localparam int REG_W  = 32;
  localparam int REG_AW = 6;

  localparam logic [REG_AW-1:0] A_STAT   = 6'h00;
  localparam logic [REG_AW-1:0] A_RXRST  = 6'h18;
  localparam logic [REG_AW-1:0] A_OCC    = 6'h1C;
  localparam logic [REG_AW-1:0] A_DATA   = 6'h20;
  localparam logic [REG_AW-1:0] A_LEN    = 6'h24;
  localparam logic [REG_AW-1:0] A_ALLRST = 6'h28;

  localparam logic [REG_W-1:0] RST_KEY = 32'h0000_00A5;

  localparam int B_UNDERREAD = 31;
  localparam int B_OVERREAD  = 30;
  localparam int B_UNDERRUN  = 29;
  localparam int B_DONE      = 26;
  localparam int B_RSTDONE   = 23;
  localparam int B_PFULL     = 20;
  localparam int B_PEMPTY    = 19;
endpackage

// File: rtl/stream_pkt_rx_fifo.sv
module stream_pkt_rx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/stream_pkt_rx_status.sv
module stream_pkt_rx_status #(
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_all,
  input  logic [SW-1:0] set_bits,
  input  logic          w1c_en,
  input  logic [SW-1:0] w1c_bits,
  output logic [SW-1:0] status,
  output logic          irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status <= '0;
    else if (clear_all) status <= '0;
    else                status <= (status & ~(w1c_en ? w1c_bits : '0)) | set_bits;
  end

  assign irq = |status;
endmodule

// File: rtl/stream_pkt_rx.sv
module stream_pkt_rx
  import stream_pkt_rx_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int LEN_DEPTH  = 4,
  parameter int PFULL_THR  = 12,
  parameter int PEMPTY_THR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [REG_W-1:0]  s_data,
  input  logic              s_last,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int LW = $clog2(LEN_DEPTH+1);
  localparam logic [CW-1:0] PF_T = CW'(PFULL_THR);
  localparam logic [CW-1:0] PE_T = CW'(PEMPTY_THR);

  logic [CW-1:0]    word_cnt, committed, cur_words, rem_words, l_head, add_w;
  logic [LW-1:0]    l_cnt;
  logic [REG_W-1:0] d_dout, status, set_vec, len_bytes;
  logic             d_full, d_empty, l_full, l_empty;
  logic             hs, hs_last, wr_rxrst, wr_allrst, flush;
  logic             rd_data, rd_len, d_pop, l_pop;
  logic             pf_lvl, pe_lvl, pf_prev, pe_prev;

  // Control decode
  assign wr_rxrst  = reg_wr && (reg_addr == A_RXRST)  && (reg_wdata == RST_KEY);
  assign wr_allrst = reg_wr && (reg_addr == A_ALLRST) && (reg_wdata == RST_KEY);
  assign flush     = wr_rxrst || wr_allrst;
  assign s_ready   = !d_full && !l_full && !flush;
  assign hs        = s_valid && s_ready;
  assign hs_last   = hs && s_last;
  assign rd_data   = reg_rd && (reg_addr == A_DATA);
  assign rd_len    = reg_rd && (reg_addr == A_LEN);
  assign d_pop     = rd_data && (committed != '0) && (rem_words != '0);
  assign l_pop     = rd_len && !l_empty;
  assign add_w     = hs_last ? CW'(cur_words + 1'b1) : '0;

  stream_pkt_rx_fifo #(.W(REG_W), .DEPTH(DEPTH)) i_data_q (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(hs), .din(s_data), .pop(d_pop), .dout(d_dout),
    .count(word_cnt), .full(d_full), .empty(d_empty)
  );

  stream_pkt_rx_fifo #(.W(CW), .DEPTH(LEN_DEPTH)) i_len_q (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(hs_last), .din(add_w), .pop(l_pop), .dout(l_head),
    .count(l_cnt), .full(l_full), .empty(l_empty)
  );

  // Packet accounting
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_words <= '0; committed <= '0; rem_words <= '0;
    end else if (flush) begin
      cur_words <= '0; committed <= '0; rem_words <= '0;
    end else begin
      if (hs) cur_words <= s_last ? '0 : cur_words + 1'b1;
      committed <= committed + add_w - CW'(d_pop);
      if (l_pop)      rem_words <= l_head;
      else if (d_pop) rem_words <= rem_words - 1'b1;
    end
  end

  // Threshold crossing detection
  assign pf_lvl = (word_cnt >= PF_T);
  assign pe_lvl = (word_cnt <= PE_T);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_prev <= 1'b0; pe_prev <= 1'b1;
    end else if (wr_allrst) begin
      pf_prev <= 1'b0; pe_prev <= 1'b1;
    end else begin
      pf_prev <= pf_lvl; pe_prev <= pe_lvl;
    end
  end

  always_comb begin
    set_vec              = '0;
    set_vec[B_UNDERREAD] = rd_len && (rem_words != '0);
    set_vec[B_OVERREAD]  = rd_data && (committed != '0) && (rem_words == '0);
    set_vec[B_UNDERRUN]  = rd_data && (committed == '0);
    set_vec[B_DONE]      = hs_last;
    set_vec[B_RSTDONE]   = wr_rxrst;
    set_vec[B_PFULL]     = pf_lvl && !pf_prev;
    set_vec[B_PEMPTY]    = pe_lvl && !pe_prev;
  end

  stream_pkt_rx_status #(.SW(REG_W)) i_status (
    .clk(clk), .rst_n(rst_n), .clear_all(wr_allrst), .set_bits(set_vec),
    .w1c_en(reg_wr && (reg_addr == A_STAT)), .w1c_bits(reg_wdata),
    .status(status), .irq(irq)
  );

  // Read data path
  assign len_bytes = {{(REG_W-CW-2){1'b0}}, l_head, 2'b00};

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = status;
      A_OCC:   reg_rdata = {{(REG_W-CW){1'b0}}, committed};
      A_DATA:  reg_rdata = d_pop ? d_dout : '0;
      A_LEN:   reg_rdata = l_empty ? '0 : len_bytes;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/stream_pkt_rx_chk.sv
module stream_pkt_rx_chk
  import stream_pkt_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic              s_ready,
  input logic              s_last,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [REG_AW-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  reg_rdata,
  input logic [REG_W-1:0]  status,
  input logic [CW-1:0]     word_cnt,
  input logic [CW-1:0]     committed,
  input logic [CW-1:0]     rem_words
);
  // R9 (input rule: one register access per cycle)
  access_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_wr));

  // R1
  ready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_cnt == CW'(DEPTH)) |-> !s_ready);

  // R3
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    committed <= word_cnt);

  // R2
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && s_last) |=> status[B_DONE]);

  // R6
  underrun_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_DATA && committed == '0) |-> (reg_rdata == '0));

  // R6
  underrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_DATA && committed == '0) |=> status[B_UNDERRUN]);

  // R8
  underread_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_LEN && rem_words != '0) |=> status[B_UNDERREAD]);

  // R10
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_RXRST && reg_wdata == RST_KEY)
      |=> (committed == '0 && status[B_RSTDONE]));

  // R11
  all_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_ALLRST && reg_wdata == RST_KEY)
      |=> (status == '0 && word_cnt == '0));
endmodule

bind stream_pkt_rx stream_pkt_rx_chk #(.DEPTH(DEPTH), .CW(CW)) i_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .s_last(s_last), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .status(status),
  .word_cnt(word_cnt), .committed(committed), .rem_words(rem_words)
);

// File: tb/test_stream_pkt_rx.sv
module test_stream_pkt_rx;
  import stream_pkt_rx_pkg::*;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0, s_last = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic        s_ready, irq;
  logic [31:0] s_data = '0, reg_wdata = '0, reg_rdata;
  logic [5:0]  reg_addr = '0;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] exp_q[$];
  int          exp_len_q[$];

  always #(CLK_P/2) clk = ~clk;

  stream_pkt_rx i_stream_pkt_rx (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic push_word(input logic [31:0] d, input logic l);
    @(negedge clk);
    s_valid = 1'b1; s_data = d; s_last = l;
    #1;
    while (!s_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  // Driver: sends a packet and records what the reader must see
  task automatic send_pkt(input int n, input logic [31:0] base);
    exp_len_q.push_back(n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(base + 32'(i));
      push_word(base + 32'(i), i == n-1);
    end
  endtask

  task automatic reg_read(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic read_status(output logic [31:0] v);
    @(posedge clk);
    reg_read(A_STAT, v);
  endtask

  // Monitor: pops the scoreboard while reading one packet out
  task automatic read_pkt();
    logic [31:0] v, e;
    int el;
    el = exp_len_q.pop_front();
    reg_read(A_LEN, v);
    check(v == 32'(el*4), "R4 length bytes", v, 32'(el*4));
    for (int i = 0; i < el; i++) begin
      e = exp_q.pop_front();
      reg_read(A_DATA, v);
      check(v == e, "R5 data order", v, e);
    end
  endtask

  initial begin
    #(CLK_P*100000);
    n_fail++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // Reset state
    #1;
    check(s_ready == 1'b1, "R1 ready after reset", 32'(s_ready), 1);
    check(irq == 1'b0, "R9 irq after reset", 32'(irq), 0);
    reg_read(A_OCC, v);
    check(v == 0, "R3 occupancy after reset", v, 0);

    // Partial packet is not counted until its last word arrives
    exp_len_q.push_back(3);
    for (int i = 0; i < 3; i++) exp_q.push_back(32'hA000 + 32'(i));
    push_word(32'hA000, 1'b0);
    push_word(32'hA001, 1'b0);
    reg_read(A_OCC, v);
    check(v == 0, "R3 partial not counted", v, 0);
    push_word(32'hA002, 1'b1);
    reg_read(A_OCC, v);
    check(v == 3, "R3 complete counted", v, 3);
    read_status(v);
    check(v[B_DONE] == 1'b1, "R2 done flag", v, 32'h1 << B_DONE);
    check(irq == 1'b1, "R9 irq high", 32'(irq), 1);

    // Write-one-to-clear
    reg_write(A_STAT, 32'h1 << B_DONE);
    read_status(v);
    check(v[B_DONE] == 1'b0, "R9 w1c clears", v, 0);
    check(irq == 1'b0, "R9 irq low after clear", 32'(irq), 0);

    // Two packets; over-read between them must not consume
    send_pkt(2, 32'hB000);
    read_pkt();
    reg_read(A_DATA, v);
    check(v == 0, "R7 over-read returns zero", v, 0);
    read_status(v);
    check(v[B_OVERREAD] == 1'b1, "R7 over-read flag", v, 32'h1 << B_OVERREAD);
    read_pkt();
    reg_read(A_OCC, v);
    check(v == 0, "R3 drained", v, 0);

    // Underrun and empty length
    reg_write(A_STAT, 32'hFFFF_FFFF);
    reg_read(A_DATA, v);
    check(v == 0, "R6 underrun returns zero", v, 0);
    read_status(v);
    check(v[B_UNDERRUN] == 1'b1, "R6 underrun flag", v, 32'h1 << B_UNDERRUN);
    reg_read(A_LEN, v);
    check(v == 0, "R4 empty length", v, 0);

    // Under-read, then receive reset (wrong key first)
    reg_write(A_STAT, 32'hFFFF_FFFF);
    send_pkt(3, 32'hC000);
    send_pkt(1, 32'hD000);
    reg_read(A_LEN, v);
    check(v == 12, "R4 length of 3-word packet", v, 12);
    reg_read(A_DATA, v);
    check(v == 32'hC000, "R5 first word", v, 32'hC000);
    reg_read(A_LEN, v);
    check(v == 4, "R4 next length", v, 4);
    read_status(v);
    check(v[B_UNDERREAD] == 1'b1, "R8 under-read flag", v, 32'h1 << B_UNDERREAD);
    reg_write(A_RXRST, 32'h0000_005A);
    reg_read(A_OCC, v);
    check(v == 3, "R10 wrong key ignored", v, 3);
    reg_write(A_RXRST, RST_KEY);
    reg_read(A_OCC, v);
    check(v == 0, "R10 flush occupancy", v, 0);
    read_status(v);
    check(v[B_RSTDONE] == 1'b1, "R10 reset-done flag", v, 32'h1 << B_RSTDONE);
    reg_read(A_LEN, v);
    check(v == 0, "R10 length queue flushed", v, 0);
    exp_q.delete();
    exp_len_q.delete();

    // Length queue full back-pressure
    for (int p = 0; p < 4; p++) send_pkt(1, 32'hE000 + 32'(p*16));
    @(negedge clk); #1;
    check(s_ready == 1'b0, "R1 length queue full", 32'(s_ready), 0);
    read_pkt();
    @(negedge clk); #1;
    check(s_ready == 1'b1, "R1 ready again", 32'(s_ready), 1);
    reg_write(A_RXRST, RST_KEY);
    exp_q.delete();
    exp_len_q.delete();

    // Data store full, thresholds
    send_pkt(16, 32'hF000);
    @(negedge clk); #1;
    check(s_ready == 1'b0, "R1 data store full", 32'(s_ready), 0);
    read_status(v);
    check(v[B_PFULL] == 1'b1, "R12 high threshold flag", v, 32'h1 << B_PFULL);
    reg_write(A_STAT, 32'hFFFF_FFFF);
    begin
      int el;
      logic [31:0] e;
      el = exp_len_q.pop_front();
      reg_read(A_LEN, v);
      check(v == 64, "R4 full packet length", v, 64);
      for (int i = 0; i < el; i++) begin
        e = exp_q.pop_front();
        reg_read(A_DATA, v);
        check(v == e, "R5 full packet data", v, e);
        if (i == 12) begin
          read_status(v);
          check(v[B_PEMPTY] == 1'b0, "R12 low flag not yet", v, 0);
        end
        if (i == 13) begin
          read_status(v);
          check(v[B_PEMPTY] == 1'b1, "R12 low threshold flag", v, 32'h1 << B_PEMPTY);
        end
      end
    end

    // Full reset clears status and data
    send_pkt(2, 32'h1000);
    reg_read(A_DATA, v);
    reg_write(A_ALLRST, RST_KEY);
    read_status(v);
    check(v == 0, "R11 status cleared", v, 0);
    check(irq == 1'b0, "R11 irq low", 32'(irq), 0);
    reg_read(A_OCC, v);
    check(v == 0, "R11 occupancy cleared", v, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule